// File: doc/BRIEF.md
# External-Bus DMA Receive Channel

This block moves a stream of bytes from an external device into on-chip memory. The device uses a parallel DMA-style handshake. Software sets the channel to receive direction and burst operation, loads a start address and a last address, and sets the enable bit. The channel then raises its DMA request. It keeps the request raised from byte to byte and takes each byte the device strobes in while the select and acknowledge qualifiers are valid.

Each accepted byte goes into a one-byte receive buffer. From there it is written to internal memory at the current counter address. The write waits for the memory acknowledge, and then the counter steps. The channel stops in one of two ways. The first is that the byte at the last address is committed: the channel then raises a completion interrupt and clears its own enable bit. The second is that the device raises its terminal-count line. That line is synchronized and edge-detected, and it withdraws the request. A write that is in flight when terminal count arrives still finishes, and the counter does not step past it.

The write strobe and terminal count are asynchronous. Each passes through a two-flop synchronizer and a rising-edge detector. If the device strobes a byte in before the buffer has been committed, the channel sets an overrun flag and drops the new byte.

Top module: `ebdma_rx_chan`

## Requirements
- R1: After reset, `ext_dreq`, `mem_we`, `irq` and `ovr` are 0 and `mem_addr` is 0.
- R2: The channel is active only when the control register holds direction field bits[1:0] = 01, burst bit[2] = 1 and enable bit[3] = 1. When it is not active, `ext_dreq` stays 0 and external writes cause no memory write.
- R3: In burst operation, `ext_dreq` stays 1 between bytes until the transfer ends.
- R4: A byte is accepted only on a rising edge of the synchronized `ext_wr` while `ext_cs` = 1 and `ext_dack_n` = 0. It is then stored at the current counter address. A strobe that lacks either qualifier is ignored.
- R5: While `mem_we` = 1 and `mem_ack` = 0, `mem_we`, `mem_addr` and `mem_wdata` hold steady. After the acknowledge, the counter steps by one, unless the byte went to the last address or terminal count is pending.
- R6: When the write to the end address is acknowledged, `irq` rises on the second clock edge after the accepting edge. The enable bit clears, `ext_dreq` falls, and `mem_addr` stays at the end address.
- R7: A rising edge on `ext_tc` while the channel is idle and active drops `ext_dreq` on the third clock edge after the input changes, with no interrupt. Later external writes are ignored.
- R8: When terminal count arrives during a pending memory write, `ext_dreq` falls and the write still completes. The channel then stops with `mem_addr` at the written address and `irq` = 0.
- R9: An accepted strobe that arrives before the previous byte is committed sets `ovr`. The new byte is dropped: there is one memory write in total and the counter steps only once.
- R10: A write to register address 3 clears `irq` where data bit 0 is 1 and clears `ovr` where data bit 1 is 1. Zero bits leave the flag unchanged.
- R11: Register address 0 holds control bits[3:0], address 1 loads the address counter, and address 2 holds the end address. Register writes take effect on the clock edge where `reg_we` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| ext_cs | input | 1 | Device chip select, active high |
| ext_dack_n | input | 1 | DMA acknowledge, active low |
| ext_wr | input | 1 | Asynchronous write strobe, active high |
| ext_tc | input | 1 | Asynchronous terminal count |
| ext_data | input | 8 | Byte from the device |
| ext_dreq | output | 1 | DMA request to the device |
| mem_we | output | 1 | Internal memory write request |
| mem_addr | output | 16 | Address counter / memory address |
| mem_wdata | output | 8 | Byte being written |
| mem_ack | input | 1 | Memory acknowledge |
| irq | output | 1 | Transfer-complete interrupt flag |
| ovr | output | 1 | Overrun flag |

## Verification
The latency of each result depends on the clock edges that follow a stimulus. A strobe or terminal-count change becomes visible on the second edge after it is driven and takes effect on the third. The memory request follows one edge after the capture, and the interrupt rises two edges after the accepting acknowledge edge. The bench drives every input at a falling edge and counts falling edges from that point. It samples the request drop and the interrupt rise at exactly those edges, and it confirms one edge earlier that the old value is still present. Memory contents, counter position and flags are compared only after the request has dropped and the channel has settled.

// File: rtl/ebdma_pkg.sv
package ebdma_pkg;
    localparam int CTRL_W = 4;
    localparam logic [1:0] DIR_RX = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CAPT  = 2'd1,
        ST_MEMWR = 2'd2,
        ST_CHECK = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_ADDR = 2'd1,
        RA_END  = 2'd2,
        RA_STAT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       en;
        logic       burst;
        logic [1:0] dir;
    } ctrl_t;

    function automatic logic rx_burst_ok(ctrl_t c);
        return c.en && c.burst && (c.dir == DIR_RX);
    endfunction
endpackage

// File: rtl/ebdma_sync_rise.sv
module ebdma_sync_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], async_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    // R7: a detected edge lasts exactly one cycle
    p_rise_single_r7: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/ebdma_regs.sv
module ebdma_regs
    import ebdma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              cnt_inc,
    input  logic              en_clr,
    input  logic              irq_set,
    input  logic              ovr_set,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] cnt,
    output logic              at_end,
    output logic              irq,
    output logic              ovr
);
    logic [ADDR_W-1:0] end_addr;
    reg_addr_e         sel;

    assign sel = reg_addr_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            cnt      <= '0;
            end_addr <= '0;
            irq      <= 1'b0;
            ovr      <= 1'b0;
        end else begin
            if (reg_we) begin
                case (sel)
                    RA_CTRL: ctrl     <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
                    RA_ADDR: cnt      <= reg_wdata;
                    RA_END:  end_addr <= reg_wdata;
                    RA_STAT: begin
                        if (reg_wdata[0]) irq <= 1'b0;
                        if (reg_wdata[1]) ovr <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (cnt_inc) cnt     <= cnt + 1'b1;
            if (en_clr)  ctrl.en <= 1'b0;
            if (irq_set) irq     <= 1'b1;
            if (ovr_set) ovr     <= 1'b1;
        end
    end

    assign at_end = (cnt == end_addr);

    // R9: overrun flag stays until software clears it
    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ovr && !(reg_we && sel == RA_STAT && reg_wdata[1]) |=> ovr);

    // R5: hardware step advances the counter by one
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_inc && !reg_we |=> cnt == ADDR_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/ebdma_seq.sv
module ebdma_seq
    import ebdma_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              wr_hit,
    input  logic              tc_rise,
    input  logic              at_end,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] data_in,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              cnt_inc,
    output logic              done_set,
    output logic              en_clr,
    output logic              ovr_set,
    output logic              tc_pend
);
    seq_state_e        state;
    logic [DATA_W-1:0] rx_buf;
    logic              stop_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rx_buf  <= '0;
            tc_pend <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (wr_hit && active) begin
                    rx_buf <= data_in;
                    state  <= ST_CAPT;
                end
                ST_CAPT:  state <= ST_MEMWR;
                ST_MEMWR: if (mem_ack) state <= ST_CHECK;
                default:  state <= ST_IDLE;
            endcase
            if (state == ST_CHECK)
                tc_pend <= 1'b0;
            else if (tc_rise && state != ST_IDLE)
                tc_pend <= 1'b1;
        end
    end

    assign stop_now  = tc_pend || tc_rise;
    assign mem_we    = (state == ST_MEMWR);
    assign mem_wdata = rx_buf;
    assign done_set  = (state == ST_CHECK) && at_end;
    assign cnt_inc   = (state == ST_CHECK) && !at_end && !stop_now;
    assign en_clr    = done_set || ((state == ST_CHECK) && stop_now)
                     || ((state == ST_IDLE) && tc_rise && active);
    assign ovr_set   = wr_hit && (state != ST_IDLE);

    // R5: buffered byte holds while the memory stalls
    p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we && !mem_ack |=> mem_we && $stable(mem_wdata));
endmodule

// File: rtl/ebdma_rx_chan.sv
module ebdma_rx_chan
    import ebdma_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              ext_cs,
    input  logic              ext_dack_n,
    input  logic              ext_wr,
    input  logic              ext_tc,
    input  logic [DATA_W-1:0] ext_data,
    output logic              ext_dreq,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    output logic              irq,
    output logic              ovr
);
    ctrl_t ctrl;
    logic  wr_rise, tc_rise, wr_hit, active, at_end;
    logic  cnt_inc, done_set, en_clr, ovr_set, tc_pend;

    ebdma_sync_rise #(.STAGES(SYNC_STAGES)) i_wr_sync (
        .clk(clk), .rst(rst), .async_in(ext_wr), .rise(wr_rise));

    ebdma_sync_rise #(.STAGES(SYNC_STAGES)) i_tc_sync (
        .clk(clk), .rst(rst), .async_in(ext_tc), .rise(tc_rise));

    ebdma_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cnt_inc(cnt_inc), .en_clr(en_clr),
        .irq_set(done_set), .ovr_set(ovr_set), .ctrl(ctrl),
        .cnt(mem_addr), .at_end(at_end), .irq(irq), .ovr(ovr));

    assign active = rx_burst_ok(ctrl);
    assign wr_hit = wr_rise && ext_cs && !ext_dack_n;

    ebdma_seq #(.DATA_W(DATA_W)) i_seq (
        .clk(clk), .rst(rst), .active(active), .wr_hit(wr_hit),
        .tc_rise(tc_rise), .at_end(at_end), .mem_ack(mem_ack),
        .data_in(ext_data), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .cnt_inc(cnt_inc), .done_set(done_set), .en_clr(en_clr),
        .ovr_set(ovr_set), .tc_pend(tc_pend));

    assign ext_dreq = active && !tc_pend;

    // R5: address holds while the memory stalls
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we && !mem_ack && !reg_we |=> $stable(mem_addr));

    // R6: completion follows an acknowledged write two edges earlier
    p_irq_after_write_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(mem_we && mem_ack, 2));

    // R6: request is withdrawn once completion is flagged
    p_quiet_after_done_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !ext_dreq);
endmodule

// File: tb/test_ebdma_rx_chan.sv
`timescale 1ns/1ps
module test_ebdma_rx_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        ext_cs = 1'b0, ext_dack_n = 1'b1, ext_wr = 1'b0, ext_tc = 1'b0;
    logic [7:0]  ext_data = '0;
    logic        ext_dreq, mem_we, mem_ack, irq, ovr;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;

    logic        ack_rand = 1'b1, ack_force = 1'b1, rnd_bit = 1'b0;
    int          checks = 0, errors = 0, wr_count = 0;
    bit          done_flag = 0;
    logic [7:0]  bmem [int];
    logic [7:0]  exp_b [16];

    always #2.5 clk = ~clk;

    ebdma_rx_chan i_ebdma_rx_chan (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ext_cs(ext_cs), .ext_dack_n(ext_dack_n),
        .ext_wr(ext_wr), .ext_tc(ext_tc), .ext_data(ext_data),
        .ext_dreq(ext_dreq), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .irq(irq), .ovr(ovr));

    assign mem_ack = mem_we && (ack_rand ? rnd_bit : ack_force);

    always @(negedge clk) rnd_bit <= ($urandom_range(0, 2) == 0);

    always @(posedge clk) if (mem_we && mem_ack) begin
        bmem[int'(mem_addr)] = mem_wdata;
        wr_count++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] ctrl_word(input logic en, input logic burst, input logic [1:0] dir);
        return {12'd0, en, burst, dir};
    endfunction

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic ext_pulse(input logic [7:0] b, input logic cs, input logic dn);
        @(negedge clk); ext_wr = 1'b1; ext_data = b; ext_cs = cs; ext_dack_n = dn;
        repeat (4) @(negedge clk);
        ext_wr = 1'b0;
        repeat (4) @(negedge clk);
        ext_cs = 1'b0; ext_dack_n = 1'b1;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        while (mem_we) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic tc_pulse();
        @(negedge clk); ext_tc = 1'b1;
        repeat (4) @(negedge clk);
        ext_tc = 1'b0;
    endtask

    task automatic arm(input logic [15:0] s, input logic [15:0] e);
        reg_wr(2'd1, s); reg_wr(2'd2, e); reg_wr(2'd0, ctrl_word(1, 1, 2'b01));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        logic [15:0] s, e;
        int len, bad;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!ext_dreq && !mem_we && !irq && !ovr, "R1 flags", {ext_dreq, mem_we, irq, ovr}, 0);
        chk(mem_addr == 16'h0, "R1 addr", mem_addr, 0);

        // R2 wrong direction: no request, writes ignored
        reg_wr(2'd1, 16'h0100); reg_wr(2'd2, 16'h0107);
        reg_wr(2'd0, ctrl_word(1, 1, 2'b10));
        c0 = wr_count;
        ext_pulse(8'h11, 1, 0); settle();
        chk(!ext_dreq, "R2 dreq dir", ext_dreq, 0);
        chk(wr_count == c0, "R2 no write", wr_count - c0, 0);
        reg_wr(2'd0, ctrl_word(1, 0, 2'b01));
        chk(!ext_dreq, "R2 dreq burst0", ext_dreq, 0);

        // R11 / R2 valid programming
        reg_wr(2'd0, ctrl_word(1, 1, 2'b01));
        chk(ext_dreq, "R2 dreq on", ext_dreq, 1);
        chk(mem_addr == 16'h0100, "R11 addr load", mem_addr, 16'h0100);

        // R4 unqualified strobes ignored
        c0 = wr_count;
        ext_pulse(8'h22, 0, 0); settle();
        ext_pulse(8'h33, 1, 1); settle();
        chk(wr_count == c0, "R4 unqualified", wr_count - c0, 0);
        chk(mem_addr == 16'h0100, "R4 addr unchanged", mem_addr, 16'h0100);

        // R3 / R4 burst of 7 random bytes
        for (int i = 0; i < 7; i++) begin
            exp_b[i] = 8'($urandom);
            ext_pulse(exp_b[i], 1, 0); settle();
            chk(ext_dreq, "R3 dreq held", ext_dreq, 1);
        end
        // R5 / R6 last byte with directed stall
        exp_b[7] = 8'hA5;
        ack_rand = 1'b0; ack_force = 1'b0;
        ext_pulse(exp_b[7], 1, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(mem_we && mem_addr == 16'h0107 && mem_wdata == 8'hA5, "R5 stall hold",
                {mem_we, mem_addr}, {1'b1, 16'h0107});
        end
        ack_force = 1'b1;
        @(negedge clk); ack_force = 1'b0;
        chk(!irq, "R6 irq not yet", irq, 0);
        @(negedge clk);
        chk(irq, "R6 irq rise", irq, 1);
        chk(!ext_dreq, "R6 dreq drop", ext_dreq, 0);
        chk(mem_addr == 16'h0107, "R6 addr end", mem_addr, 16'h0107);
        bad = 0;
        for (int i = 0; i < 8; i++) if (bmem[32'h100 + i] !== exp_b[i]) bad++;
        chk(bad == 0, "R4 memory contents", bad, 0);
        ack_rand = 1'b1;

        // R10 W1C
        reg_wr(2'd3, 16'h0000);
        chk(irq, "R10 zero keeps", irq, 1);
        reg_wr(2'd3, 16'h0001);
        chk(!irq, "R10 clear irq", irq, 0);

        // R7 terminal count while idle
        arm(16'h0200, 16'h020F);
        c0 = wr_count;
        ext_pulse(8'h41, 1, 0); settle();
        ext_pulse(8'h42, 1, 0); settle();
        @(negedge clk); ext_tc = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(ext_dreq, "R7 dreq before", ext_dreq, 1);
        @(negedge clk);
        chk(!ext_dreq, "R7 dreq after", ext_dreq, 0);
        repeat (2) @(negedge clk); ext_tc = 1'b0;
        chk(mem_addr == 16'h0202 && !irq, "R7 addr no irq", {irq, mem_addr}, 16'h0202);
        ext_pulse(8'h43, 1, 0); settle();
        chk(wr_count - c0 == 2, "R7 later ignored", wr_count - c0, 2);

        // R8 terminal count during pending write
        arm(16'h0300, 16'h030F);
        c0 = wr_count;
        ack_rand = 1'b0; ack_force = 1'b0;
        ext_pulse(8'h5C, 1, 0);
        tc_pulse();
        @(negedge clk);
        chk(!ext_dreq && mem_we, "R8 dreq drop", {ext_dreq, mem_we}, 1);
        ack_force = 1'b1; settle(); ack_rand = 1'b1;
        chk(bmem[32'h300] === 8'h5C && wr_count - c0 == 1, "R8 write done", wr_count - c0, 1);
        chk(mem_addr == 16'h0300 && !irq, "R8 addr held", {irq, mem_addr}, 16'h0300);

        // R9 overrun
        arm(16'h0400, 16'h040F);
        c0 = wr_count;
        ack_rand = 1'b0; ack_force = 1'b0;
        ext_pulse(8'h61, 1, 0);
        ext_pulse(8'h62, 1, 0);
        chk(ovr, "R9 ovr set", ovr, 1);
        ack_force = 1'b1; settle(); ack_rand = 1'b1;
        chk(bmem[32'h400] === 8'h61 && wr_count - c0 == 1, "R9 dropped", wr_count - c0, 1);
        chk(mem_addr == 16'h0401, "R9 single step", mem_addr, 16'h0401);
        reg_wr(2'd3, 16'h0002);
        chk(!ovr, "R10 clear ovr", ovr, 0);
        reg_wr(2'd0, 16'h0000);

        // R3 / R6 random runs
        for (int r = 0; r < 6; r++) begin
            len = $urandom_range(1, 6);
            s = 16'h1000 + 16'(r * 32) + 16'($urandom_range(0, 7));
            e = s + 16'(len - 1);
            arm(s, e);
            for (int i = 0; i < len; i++) begin
                exp_b[i] = 8'($urandom);
                ext_pulse(exp_b[i], 1, 0); settle();
                if (i < len - 1) chk(ext_dreq, "R3 random held", ext_dreq, 1);
            end
            bad = 0;
            for (int i = 0; i < len; i++) if (bmem[int'(s) + i] !== exp_b[i]) bad++;
            chk(bad == 0, "R4 random contents", bad, 0);
            chk(irq && !ext_dreq && mem_addr == e, "R6 random end", mem_addr, e);
            reg_wr(2'd3, 16'h0001);
        end

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule